// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames as a byte stream and scatters them into a ring of receive buffer descriptors held in system memory. For each frame it walks the ring from the current descriptor. It fills each buffer up to a programmed buffer size and appends the four-byte frame check value after the payload, even when that value has to straddle two buffers. It then writes the length and status flags back into each descriptor it used.

Software arms the block with a receive-kick strobe. The block then checks the current descriptor and raises `rx_active` if that descriptor is empty. After each frame it checks the next descriptor again, and `rx_active` stays high only if that descriptor is empty as well. Frames that arrive while `rx_active` is low are drained from the stream and never reach memory. A frame that runs into a full descriptor part-way through is cut off there, and the rest of it is drained.

The byte stream uses valid/ready. A byte moves on a clock edge where `s_valid` and `s_ready` are both high. The source must hold `s_data` and `s_last` stable while `s_valid` is high and `s_ready` is low. `crc_in` must be valid with the byte that carries `s_last`. `s_ready` depends only on the block's own state, never on `s_valid`. The memory port is a request/acknowledge word port: `mem_req` and its address, data and strobes stay stable until `mem_ack`, and read data is taken in the acknowledge cycle. `ctrl_enable` may change only while no frame is in progress.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame that starts while `rx_active` is low is accepted byte by byte with `s_ready` high and then discarded. It makes no memory request and raises no event.
- R2: After the payload, four frame check bytes are stored, most significant byte of `crc_in` first. The stored length counts them.
- R3: If payload length plus 4 exceeds MAX_FRAME, only MAX_FRAME-4 payload bytes are stored and the other payload bytes are dropped. The four check bytes are still stored. The final descriptor gets flag bit 0 (truncated) and flag bit 5 (too long).
- R4: If the stored length including the check bytes exceeds `frame_limit`, the final descriptor gets flag bit 5 (too long).
- R5: The buffer size is `max_buf_size` AND 0x3FF0. Each buffer is filled up to that size before the next descriptor is used. The length field holds the number of bytes placed in that buffer.
- R6: A descriptor is 8 bytes long. Word 0 holds flags in bits 31:16 and length in bits 15:0. Word 1 holds the buffer address. Flag bit 15 means empty and flag bit 13 means wrap. Writeback clears bit 15, keeps the other flags and never writes word 1.
- R7: The final descriptor of a frame gets flag bit 11 (last) and the error flags, and produces a one-cycle `ev_rxf` pulse. Every other filled descriptor produces one `ev_rxb` pulse.
- R8: If a descriptor needed part-way through a frame is not empty, no more bytes of that frame are stored. The remaining stream bytes are drained, no descriptor is marked last, and `rx_active` falls.
- R9: After a frame completes, the next descriptor is read, and `rx_active` takes the value of its empty flag.
- R10: A kick while enabled and inactive reads the current descriptor and sets `rx_active` to its empty flag. While `ctrl_enable` is low, `rx_active` is low, kicks have no effect, and the current descriptor returns to `ring_base`. `rx_active` is low after reset.
- R11: After a descriptor is used, the next one is at `ring_base` if its wrap flag is set. Otherwise it is at the current descriptor address plus 8.
- R12: Once `mem_req` is raised, it stays high with a stable address and direction until `mem_ack`.
- R13: The byte at buffer offset j goes to byte lane j mod 4 of the word at buffer address plus (j AND ~3). `mem_be` marks exactly the lanes written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_enable | input | 1 | Controller enable |
| rx_kick | input | 1 | One-cycle receive-kick strobe |
| ring_base | input | AW | Byte address of the first descriptor |
| max_buf_size | input | 16 | Raw buffer size, masked with 0x3FF0 |
| frame_limit | input | 16 | Programmable frame length limit |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the last payload byte |
| s_ready | output | 1 | Block accepts a byte |
| crc_in | input | 32 | Frame check value, valid with the last byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte-lane write strobes |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completes |
| rx_active | output | 1 | Receive armed |
| ev_rxf | output | 1 | Frame-received pulse |
| ev_rxb | output | 1 | Buffer-received pulse |

## Verification
A table of frames runs through a freshly armed ring. The table varies payload length, buffer size and length limit. It separates a frame that fits in one buffer, a frame that exactly fills one buffer (which must still be marked last), a check value split two-and-two across buffers, buffer-size masking, the limit-only flag, and frames just at and just over the hard cap. Directed runs cover four more cases. A frame sent while disarmed must cost no memory traffic. A ring that fills mid-frame must leave no last flag and must drop `rx_active`. A two-descriptor wrap must find the first descriptor already used. The memory handshake is also watched for a request that changes or withdraws before its acknowledge.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int LW = 16;
  localparam logic [15:0] MBS_MASK = 16'h3FF0;
  localparam int F_EMPTY = 15;
  localparam int F_WRAP  = 13;
  localparam int F_LAST  = 11;
  localparam int F_LONG  = 5;
  localparam int F_TRUNC = 0;
  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_PEEK, S_RDD0, S_RDD1, S_RECV, S_WDAT, S_WDSC, S_DRAIN
  } rx_state_e;
endpackage

// File: rtl/rx_frame_meter.sv
module rx_frame_meter
  import rx_ring_pkg::*;
#(
  parameter int MAX_FRAME = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          store,
  input  logic          drop,
  input  logic          buf_new,
  input  logic [LW-1:0] mbs,
  input  logic [LW-1:0] limit,
  output logic [LW-1:0] total,
  output logic [LW-1:0] buf_cnt,
  output logic          buf_full,
  output logic          at_cap,
  output logic          trunc,
  output logic          too_long
);
  localparam logic [LW-1:0] CAP = LW'(MAX_FRAME - 4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total <= '0;
      trunc <= 1'b0;
    end else if (start) begin
      total <= '0;
      trunc <= 1'b0;
    end else begin
      if (store) total <= total + 1'b1;
      if (drop)  trunc <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       buf_cnt <= '0;
    else if (buf_new) buf_cnt <= '0;
    else if (store)   buf_cnt <= buf_cnt + 1'b1;
  end

  assign buf_full = (buf_cnt >= mbs);
  assign at_cap   = (total >= CAP);
  assign too_long = trunc | (total > limit);

  assert_frame_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    total <= LW'(MAX_FRAME));
  assert_buf_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> (buf_cnt < mbs));
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        put,
  input  logic [1:0]  lane,
  input  logic [7:0]  din,
  input  logic        clear,
  output logic [31:0] word,
  output logic [3:0]  be
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
      be   <= '0;
    end else if (clear) begin
      be <= '0;
    end else if (put) begin
      word[{lane, 3'b000} +: 8] <= din;
      be[lane] <= 1'b1;
    end
  end

  assert_lane_free_R13: assert property (@(posedge clk) disable iff (!rst_n)
    put |-> !be[lane]);
endmodule

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr
  import rx_ring_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (load)    ptr <= base;
    else if (advance) ptr <= wrap ? base : ptr + AW'(DESC_BYTES);
  end

  assert_wrap_base_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap && !load) |=> (ptr == $past(base)));
  assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap && !load) |=> (ptr == $past(ptr) + AW'(DESC_BYTES)));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MAX_FRAME = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_enable,
  input  logic          rx_kick,
  input  logic [AW-1:0] ring_base,
  input  logic [15:0]   max_buf_size,
  input  logic [15:0]   frame_limit,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  input  logic [31:0]   crc_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          rx_active,
  output logic          ev_rxf,
  output logic          ev_rxb
);
  rx_state_e     state_q;
  logic          phase_crc_q;
  logic [31:0]   crc_q;
  logic [1:0]    crc_idx_q;
  logic          fin_q;
  logic [15:0]   desc_flags_q;
  logic [AW-1:0] buf_ptr_q, wa_q;
  logic          rx_active_q, kick_pend_q, ev_rxf_q, ev_rxb_q;

  logic [AW-1:0] desc_ptr;
  logic [LW-1:0] m_total, m_buf_cnt;
  logic          m_buf_full, m_at_cap, m_trunc, m_too_long;
  logic [31:0]   pk_word;
  logic [3:0]    pk_be;

  logic [LW-1:0] mbs;
  logic          pay_mode, want_byte, last_byte;
  logic          store_now, drop_now, close_now;
  logic          idle_peek, frame_go;
  logic [7:0]    cur_byte;
  logic [15:0]   flags_out;
  logic          rd_empty;

  assign mbs       = max_buf_size & MBS_MASK;
  assign pay_mode  = (state_q == S_RECV) && !phase_crc_q;
  assign cur_byte  = phase_crc_q ? crc_q[{~crc_idx_q, 3'b000} +: 8] : s_data;
  assign last_byte = phase_crc_q && (crc_idx_q == 2'd3);
  // a byte waiting to be placed into a buffer
  assign want_byte = phase_crc_q || (s_valid && !m_at_cap);
  assign store_now = (state_q == S_RECV) && !m_buf_full && want_byte;
  assign close_now = (state_q == S_RECV) && m_buf_full && want_byte;
  assign drop_now  = pay_mode && s_valid && m_at_cap;
  assign s_ready   = (state_q == S_DRAIN) || (pay_mode && (m_at_cap || !m_buf_full));

  assign idle_peek = kick_pend_q && ctrl_enable && !rx_active_q;
  assign frame_go  = (state_q == S_IDLE) && !idle_peek && s_valid && rx_active_q;
  assign rd_empty  = mem_rdata[16 + F_EMPTY];

  always_comb begin
    flags_out = desc_flags_q & ~(16'(1) << F_EMPTY);
    if (fin_q) begin
      flags_out[F_LAST] = 1'b1;
      if (m_too_long) flags_out[F_LONG]  = 1'b1;
      if (m_trunc)    flags_out[F_TRUNC] = 1'b1;
    end
  end

  rx_frame_meter #(.MAX_FRAME(MAX_FRAME)) u_meter (
    .clk(clk), .rst_n(rst_n), .start(frame_go), .store(store_now), .drop(drop_now),
    .buf_new((state_q == S_RDD1) && mem_ack), .mbs(mbs), .limit(frame_limit),
    .total(m_total), .buf_cnt(m_buf_cnt), .buf_full(m_buf_full), .at_cap(m_at_cap),
    .trunc(m_trunc), .too_long(m_too_long)
  );

  rx_word_packer u_pack (
    .clk(clk), .rst_n(rst_n), .put(store_now), .lane(m_buf_cnt[1:0]), .din(cur_byte),
    .clear((state_q == S_WDAT) && mem_ack), .word(pk_word), .be(pk_be)
  );

  rx_ring_ptr #(.AW(AW)) u_ring (
    .clk(clk), .rst_n(rst_n), .load((state_q == S_IDLE) && !ctrl_enable), .base(ring_base),
    .advance((state_q == S_WDSC) && mem_ack), .wrap(desc_flags_q[F_WRAP]), .ptr(desc_ptr)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_ptr;
    mem_wdata = '0;
    mem_be    = '0;
    unique case (state_q)
      S_PEEK, S_RDD0: mem_req = 1'b1;
      S_RDD1: begin
        mem_req  = 1'b1;
        mem_addr = desc_ptr + AW'(4);
      end
      S_WDAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = wa_q;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      S_WDSC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {flags_out, m_buf_cnt};
        mem_be    = 4'hF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      phase_crc_q  <= 1'b0;
      crc_q        <= '0;
      crc_idx_q    <= '0;
      fin_q        <= 1'b0;
      desc_flags_q <= '0;
      buf_ptr_q    <= '0;
      wa_q         <= '0;
      rx_active_q  <= 1'b0;
      kick_pend_q  <= 1'b0;
      ev_rxf_q     <= 1'b0;
      ev_rxb_q     <= 1'b0;
    end else begin
      ev_rxf_q    <= 1'b0;
      ev_rxb_q    <= 1'b0;
      kick_pend_q <= kick_pend_q | rx_kick;
      unique case (state_q)
        S_IDLE: begin
          if (kick_pend_q) kick_pend_q <= rx_kick;
          if (idle_peek) begin
            state_q <= S_PEEK;
          end else if (s_valid) begin
            phase_crc_q <= 1'b0;
            crc_idx_q   <= '0;
            fin_q       <= 1'b0;
            state_q     <= rx_active_q ? S_RDD0 : S_DRAIN;
          end
        end
        S_PEEK: if (mem_ack) begin
          rx_active_q <= rd_empty;
          state_q     <= S_IDLE;
        end
        S_RDD0: if (mem_ack) begin
          if (rd_empty) begin
            desc_flags_q <= mem_rdata[31:16];
            state_q      <= S_RDD1;
          end else begin
            rx_active_q <= 1'b0;
            state_q     <= phase_crc_q ? S_IDLE : S_DRAIN;
          end
        end
        S_RDD1: if (mem_ack) begin
          buf_ptr_q <= mem_rdata[AW-1:0] & ~AW'(3);
          state_q   <= S_RECV;
        end
        S_RECV: begin
          if (close_now) begin
            fin_q   <= 1'b0;
            state_q <= S_WDSC;
          end else begin
            if (store_now) begin
              wa_q <= buf_ptr_q + AW'({m_buf_cnt[LW-1:2], 2'b00});
              if (phase_crc_q) crc_idx_q <= crc_idx_q + 1'b1;
              if ((m_buf_cnt[1:0] == 2'd3) || last_byte) begin
                fin_q   <= last_byte;
                state_q <= S_WDAT;
              end
            end
            if ((store_now || drop_now) && !phase_crc_q && s_last) begin
              phase_crc_q <= 1'b1;
              crc_q       <= crc_in;
              crc_idx_q   <= '0;
            end
          end
        end
        S_WDAT: if (mem_ack) state_q <= fin_q ? S_WDSC : S_RECV;
        S_WDSC: if (mem_ack) begin
          ev_rxf_q <= fin_q;
          ev_rxb_q <= !fin_q;
          state_q  <= fin_q ? S_PEEK : S_RDD0;
        end
        S_DRAIN: if (s_valid && s_last) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
      if (!ctrl_enable) rx_active_q <= 1'b0;
    end
  end

  assign rx_active = rx_active_q;
  assign ev_rxf    = ev_rxf_q;
  assign ev_rxb    = ev_rxb_q;

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_off_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_enable |=> !rx_active);
  assert_rxf_after_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxf |-> $past(mem_ack && mem_we && (mem_be == 4'hF)));
  assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rxf, ev_rxb}));
endmodule

// File: tb/rx_ring_writer_bench.sv
`timescale 1ns/1ps
module rx_ring_writer_bench;
  localparam int AW = 16;
  localparam int MAXF = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_enable = 1'b0, rx_kick = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic [15:0] max_buf_size = 16'h0010, frame_limit = 16'h05EE;
  logic s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [7:0] s_data = '0;
  logic [31:0] crc_in = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [3:0] mem_be;
  logic rx_active, ev_rxf, ev_rxb;

  always #2 clk = ~clk;

  rx_ring_writer #(.AW(AW), .MAX_FRAME(MAXF)) u_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .rx_kick(rx_kick),
    .ring_base(ring_base), .max_buf_size(max_buf_size), .frame_limit(frame_limit),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .crc_in(crc_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .rx_active(rx_active), .ev_rxf(ev_rxf), .ev_rxb(ev_rxb)
  );

  // memory model: one-cycle acknowledge, protocol watch
  logic [31:0] mem [0:511];
  int ack_n = 0, rxf_n = 0, rxb_n = 0, viol_n = 0, cyc = 0;
  logic hold_q = 1'b0;
  logic [AW-1:0] haddr_q = '0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (ev_rxf) rxf_n = rxf_n + 1;
    if (ev_rxb) rxb_n = rxb_n + 1;
    if (hold_q && (!mem_req || mem_addr != haddr_q)) viol_n = viol_n + 1;
    hold_q  <= rst_n && mem_req && !mem_ack;
    haddr_q <= mem_addr;
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      ack_n = ack_n + 1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] = mem_wdata[8*b +: 8];
      end
      mem_rdata <= mem[mem_addr[10:2]];
    end else mem_ack <= 1'b0;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_byte(input int a);
    return mem[a >> 2][8*(a & 3) +: 8];
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = '0;
  endtask

  // descriptor d: flags E=bit15, W=bit13 in word bits 31:16; buffer at 0x100+64*d
  task automatic put_desc(input int d, input bit empty, input bit wrap);
    mem[2*d]     = {(empty ? 16'h8000 : 16'h0) | (wrap ? 16'h2000 : 16'h0), 16'h0};
    mem[2*d + 1] = 32'h100 + 32'(d * 64);
  endtask

  task automatic arm();
    @(negedge clk); ctrl_enable = 1'b0;
    repeat (3) @(negedge clk);
    ctrl_enable = 1'b1; rx_kick = 1'b1;
    @(negedge clk); rx_kick = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic send(input int len, input logic [7:0] seed, input logic [31:0] crc);
    crc_in = crc;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = seed + 8'(i); s_last = (i == len - 1);
      while (!s_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  // {payload length, raw buffer size, frame limit}
  localparam logic [47:0] VEC [0:7] = '{
    {16'd10, 16'h0010, 16'h05EE},   // single buffer
    {16'd20, 16'h001F, 16'h05EE},   // masked size, two buffers
    {16'd14, 16'h0010, 16'h05EE},   // check value split 2+2
    {16'd12, 16'h0010, 16'h05EE},   // exact fill, still last
    {16'd28, 16'h0010, 16'h0014},   // over limit only
    {16'd70, 16'h0020, 16'h05EE},   // truncated
    {16'd60, 16'h0030, 16'h0040},   // exactly at cap
    {16'd61, 16'hC030, 16'h05EE}    // one over cap
  };

  initial begin
    int a0, b0, k0, len, mbs, lim, n, nb, pay, blen, bad_p, bad_c, idx;
    logic [31:0] crc;
    logic [7:0] seed, expb;
    logic [15:0] fl;
    string ftag;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset rx_active", 32'(rx_active), 0);
    chk("R1 reset s_ready", 32'(s_ready), 0);
    chk("R12 reset mem_req", 32'(mem_req), 0);

    // vector table
    for (int v = 0; v < 8; v++) begin
      len = int'(VEC[v][47:32]); mbs = int'(VEC[v][31:16] & 16'h3FF0); lim = int'(VEC[v][15:0]);
      max_buf_size = VEC[v][31:16]; frame_limit = VEC[v][15:0];
      clear_mem();
      for (int d = 0; d < 8; d++) put_desc(d, 1'b1, d == 7);
      arm();
      chk("R10 kick arms", 32'(rx_active), 1);
      a0 = rxf_n; b0 = rxb_n;
      crc = 32'hA1B2C300 | 32'(v); seed = 8'(v * 16 + 3);
      send(len, seed, crc);
      n = (len + 4 > MAXF) ? MAXF : len + 4;
      nb = (n + mbs - 1) / mbs; pay = n - 4;
      bad_p = 0; bad_c = 0;
      for (int k = 0; k < nb; k++) begin
        blen = (n - k*mbs < mbs) ? n - k*mbs : mbs;
        fl = 16'h0;
        if (k == nb - 1) begin
          fl = 16'h0800;
          if (len + 4 > MAXF) fl = fl | 16'h0021;
          if (n > lim) fl = fl | 16'h0020;
        end
        ftag = (len + 4 > MAXF) ? "R3 trunc flags" : (n > lim) ? "R4 limit flag" : "R7 last flags";
        chk("R5 length field", {16'h0, mem[2*k][15:0]}, 32'(blen));
        chk(ftag, {16'h0, mem[2*k][31:16]}, {16'h0, fl});
        chk("R6 word1 intact", mem[2*k + 1], 32'h100 + 32'(k * 64));
        for (int j = 0; j < blen; j++) begin
          idx = k*mbs + j;
          if (idx < pay) begin
            expb = seed + 8'(idx);
            if (rd_byte(256 + 64*k + j) !== expb) bad_p++;
          end else begin
            expb = crc[8*(3 - (idx - pay)) +: 8];
            if (rd_byte(256 + 64*k + j) !== expb) bad_c++;
          end
        end
      end
      chk("R13 payload bytes", 32'(bad_p), 0);
      chk("R2 check bytes", 32'(bad_c), 0);
      chk("R5 next desc untouched", mem[2*nb], 32'h8000_0000);
      chk("R7 rxf count", 32'(rxf_n - a0), 1);
      chk("R7 rxb count", 32'(rxb_n - b0), 32'(nb - 1));
      chk("R9 active after frame", 32'(rx_active), 1);
    end

    // kick while disabled, then frame while inactive
    clear_mem();
    for (int d = 0; d < 8; d++) put_desc(d, 1'b1, d == 7);
    max_buf_size = 16'h0010; frame_limit = 16'h05EE;
    @(negedge clk); ctrl_enable = 1'b0; rx_kick = 1'b1;
    @(negedge clk); rx_kick = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 kick ignored when disabled", 32'(rx_active), 0);
    k0 = ack_n; a0 = rxf_n; b0 = rxb_n;
    send(8, 8'h40, 32'h11223344);
    chk("R1 no memory traffic", 32'(ack_n - k0), 0);
    chk("R1 no events", 32'(rxf_n - a0 + rxb_n - b0), 0);
    chk("R1 desc untouched", mem[0], 32'h8000_0000);

    // ring fills mid-frame
    clear_mem();
    for (int d = 0; d < 8; d++) put_desc(d, d != 2, 1'b0);
    arm();
    a0 = rxf_n; b0 = rxb_n;
    send(40, 8'h10, 32'hDEADBEEF);
    chk("R8 first buffer", mem[0], 32'h0000_0010);
    chk("R8 second buffer no last", mem[2], 32'h0000_0010);
    chk("R8 full desc untouched", mem[4], 32'h0000_0000);
    chk("R8 no rxf", 32'(rxf_n - a0), 0);
    chk("R8 rxb count", 32'(rxb_n - b0), 2);
    chk("R8 active dropped", 32'(rx_active), 0);

    // two-descriptor wrap
    clear_mem();
    put_desc(0, 1'b1, 1'b0); put_desc(1, 1'b1, 1'b1); put_desc(2, 1'b1, 1'b0);
    arm();
    send(8, 8'h60, 32'h0BADF00D);
    chk("R7 desc0 last", mem[0], 32'h0800_000C);
    chk("R9 next empty keeps active", 32'(rx_active), 1);
    send(8, 8'h70, 32'h0BADF00D);
    chk("R6 wrap flag kept", mem[2], 32'h2800_000C);
    chk("R11 wrapped to used desc", 32'(rx_active), 0);
    chk("R11 desc2 untouched", mem[4], 32'h8000_0000);
    chk("R12 request held until ack", 32'(viol_n), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule